// File: doc/BRIEF.md
# Run-time pad-to-function router

This block sits between a set of on-chip peripheral functions and a smaller set of physical I/O pads. Every pad carries a 2-bit select field held in a configuration register. Choice 0 hands the pad to a per-pad general-purpose I/O bit. Choices 1 to 3 each hand it to one of the peripheral functions. The chosen source sets both the pad's output level and its output-enable, so the pad's direction is switched together with its data.

In the other direction, each function input gathers the levels of all pads currently routed to it. A fixed-priority selector takes the lowest-numbered routed pad, so two pads at opposite levels never contend on one input. Functions come in three kinds, set by parameters: output-only, input-only and bidirectional. A bidirectional function supplies its own output-enable. Software programs the select fields and the general-purpose output and direction bits through a plain synchronous write port. It reads the pad levels back through a combinational read port.

Top module: `padmux_top`

## Requirements
- R1: While reset is asserted, and after it is released, every writable register is zero. Every pad therefore reads as a general-purpose input, with pad_oe = 0 and pad_out = 0.
- R2: Register layout. Pad p's select field sits in register p/4 at bits [2*(p%4)+1 : 2*(p%4)]. The output register is at address 2 and the direction register is at address 3, with bit p belonging to pad p. The pad-level register is at address 4. A select value c of 1 to 3 routes pad p to function (p + c - 1) mod NUM_FN.
- R3: With select 0, pad_out[p] equals output-register bit p and pad_oe[p] equals direction-register bit p, where 1 means drive.
- R4: A pad routed to an output-only function has pad_oe = 1 and pad_out equal to that function's fn_out bit.
- R5: A pad routed to an input-only function has pad_oe = 0 and pad_out = 0.
- R6: A pad routed to a bidirectional function takes pad_out from fn_out and pad_oe from fn_oe.
- R7: One function may be routed to several pads at once, and all of those pads carry its level and enable.
- R8: When several pads are routed to one function input, fn_in takes the level of the routed pad with the lowest index.
- R9: fn_in is 0 for a function with no pad routed to it, and it is always 0 for an output-only function.
- R10: Reading address 4 returns all pad_in levels, whatever the select fields hold.
- R11: A write updates the addressed register at the clock edge. The pad outputs change right after that edge, never before it. The written value reads back unchanged.
- R12: A write to the pad-level address, or to an unmapped address, changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (3) | Write address |
| wr_data_i | input | REG_W (8) | Write data |
| rd_addr_i | input | ADDR_W (3) | Read address |
| rd_data_o | output | REG_W (8) | Read data, combinational |
| fn_out_i | input | NUM_FN (4) | Output level from each function |
| fn_oe_i | input | NUM_FN (4) | Output-enable from each function (used by bidirectional ones) |
| fn_in_o | output | NUM_FN (4) | Resolved input level to each function |
| pad_in_i | input | NUM_PADS (8) | Level sensed at each pad |
| pad_out_o | output | NUM_PADS (8) | Level driven at each pad |
| pad_oe_o | output | NUM_PADS (8) | Drive enable of each pad |

## Verification
The routing is tried with five patterns:
- All pads on general-purpose I/O. This separates the direction bits from the function enables.
- Every pad on choice 1. Each function then reaches two pads with opposite levels on the lower one, which shows that the lower index wins.
- Only the upper four pads routed. The winner is then a high-index pad, and the lower pads stay on general-purpose I/O.
- Two mixed configurations, where one bidirectional function owns four pads with its enable first high and then low. These tell one-to-many fan-out apart from the per-kind enable rules.

Directed steps then cover the reset values, the cycle at which a write takes effect, and writes to read-only or unmapped addresses.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

    localparam int SEL_W      = 2;
    localparam int NUM_CHOICE = 1 << SEL_W;

    typedef enum logic [1:0] {
        FK_BIDIR    = 2'd0,
        FK_OUT_ONLY = 2'd1,
        FK_IN_ONLY  = 2'd2,
        FK_NONE     = 2'd3
    } fn_kind_e;

    function automatic fn_kind_e kind_of(input bit has_out, input bit has_in);
        if (has_out && has_in) return FK_BIDIR;
        if (has_out)           return FK_OUT_ONLY;
        if (has_in)            return FK_IN_ONLY;
        return FK_NONE;
    endfunction

    // function reached by a pad for a non-zero select value
    function automatic int unsigned choice_fn(input int unsigned pad,
                                              input int unsigned choice,
                                              input int unsigned nfn);
        return (pad + choice - 1) % nfn;
    endfunction

endpackage

// File: rtl/padmux_cfg_regs.sv
module padmux_cfg_regs
    import padmux_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               wr_en_i,
    input  logic [ADDR_W-1:0]                  wr_addr_i,
    input  logic [REG_W-1:0]                   wr_data_i,
    input  logic [ADDR_W-1:0]                  rd_addr_i,
    output logic [REG_W-1:0]                   rd_data_o,
    input  logic [NUM_PADS-1:0]                pad_in_i,
    output logic [NUM_PADS-1:0][SEL_W-1:0]     pad_sel_o,
    output logic [NUM_PADS-1:0]                gpio_out_o,
    output logic [NUM_PADS-1:0]                gpio_dir_o
);

    localparam int PPR       = REG_W / SEL_W;
    localparam int SEL_REGS  = (NUM_PADS + PPR - 1) / PPR;
    localparam int GPIO_REGS = (NUM_PADS + REG_W - 1) / REG_W;
    localparam int OUT_BASE  = SEL_REGS;
    localparam int DIR_BASE  = SEL_REGS + GPIO_REGS;
    localparam int IN_BASE   = DIR_BASE + GPIO_REGS;
    localparam int NUM_WR    = IN_BASE;

    logic [NUM_WR-1:0][REG_W-1:0]  cfg_q;
    logic [GPIO_REGS*REG_W-1:0]    pin_ext;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            for (int r = 0; r < NUM_WR; r++) begin
                if (int'(wr_addr_i) == r) cfg_q[r] <= wr_data_i;
            end
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_fields
        assign pad_sel_o[p]  = cfg_q[p / PPR][(p % PPR) * SEL_W +: SEL_W];
        assign gpio_out_o[p] = cfg_q[OUT_BASE + p / REG_W][p % REG_W];
        assign gpio_dir_o[p] = cfg_q[DIR_BASE + p / REG_W][p % REG_W];
    end

    assign pin_ext = (GPIO_REGS*REG_W)'(pad_in_i);

    always_comb begin
        rd_data_o = '0;
        for (int r = 0; r < NUM_WR; r++) begin
            if (int'(rd_addr_i) == r) rd_data_o = cfg_q[r];
        end
        for (int g = 0; g < GPIO_REGS; g++) begin
            if (int'(rd_addr_i) == IN_BASE + g) rd_data_o = pin_ext[g*REG_W +: REG_W];
        end
    end

    for (genvar r = 0; r < NUM_WR; r++) begin : g_wr_chk
        AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_en_i && int'(wr_addr_i) == r |=> cfg_q[r] == $past(wr_data_i)); // R11
    end

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && int'(wr_addr_i) >= NUM_WR |=> $stable(cfg_q)); // R12

    AST_IN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(rd_addr_i) == IN_BASE |-> rd_data_o[0] == pad_in_i[0]); // R10

endmodule

// File: rtl/padmux_pad_sel.sv
module padmux_pad_sel
    import padmux_pkg::*;
#(
    parameter int               PAD_IDX    = 0,
    parameter int               NUM_FN     = 4,
    parameter logic [NUM_FN-1:0] FN_HAS_OUT = '1,
    parameter logic [NUM_FN-1:0] FN_HAS_IN  = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              gpio_out_i,
    input  logic              gpio_dir_i,
    input  logic [NUM_FN-1:0] fn_out_i,
    input  logic [NUM_FN-1:0] fn_oe_i,
    output logic              pad_out_o,
    output logic              pad_oe_o
);

    logic [NUM_CHOICE-1:0] cand_out;
    logic [NUM_CHOICE-1:0] cand_oe;
    logic                  unused_fn;

    assign cand_out[0] = gpio_out_i;
    assign cand_oe[0]  = gpio_dir_i;

    for (genvar c = 1; c < NUM_CHOICE; c++) begin : g_choice
        localparam int unsigned FI   = choice_fn(PAD_IDX, c, NUM_FN);
        localparam fn_kind_e    KIND = kind_of(FN_HAS_OUT[FI], FN_HAS_IN[FI]);
        if (KIND == FK_BIDIR) begin : g_bidir
            assign cand_out[c] = fn_out_i[FI];
            assign cand_oe[c]  = fn_oe_i[FI];
            AST_BIDIR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                int'(sel_i) == c |-> pad_oe_o == fn_oe_i[FI] && pad_out_o == fn_out_i[FI]); // R6
        end else if (KIND == FK_OUT_ONLY) begin : g_out
            assign cand_out[c] = fn_out_i[FI];
            assign cand_oe[c]  = 1'b1;
            AST_OUT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
                int'(sel_i) == c |-> pad_oe_o && pad_out_o == fn_out_i[FI]); // R4
        end else begin : g_in
            assign cand_out[c] = 1'b0;
            assign cand_oe[c]  = 1'b0;
            AST_IN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
                int'(sel_i) == c |-> !pad_oe_o && !pad_out_o); // R5
        end
    end

    assign pad_out_o = cand_out[sel_i];
    assign pad_oe_o  = cand_oe[sel_i];
    assign unused_fn = ^{fn_out_i, fn_oe_i};

    AST_GPIO_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i == '0 |-> pad_oe_o == gpio_dir_i && pad_out_o == gpio_out_i); // R3

endmodule

// File: rtl/padmux_in_prio.sv
module padmux_in_prio #(
    parameter int NUM_PADS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PADS-1:0] hit_i,
    input  logic [NUM_PADS-1:0] pad_in_i,
    output logic                fn_in_o
);

    always_comb begin
        fn_in_o = 1'b0;
        for (int p = NUM_PADS - 1; p >= 0; p--) begin
            if (hit_i[p]) fn_in_o = pad_in_i[p];
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i == '0 |-> !fn_in_o); // R9

    AST_LOW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i[0] |-> fn_in_o == pad_in_i[0]); // R8

endmodule

// File: rtl/padmux_top.sv
module padmux_top
    import padmux_pkg::*;
#(
    parameter int                NUM_PADS   = 8,
    parameter int                NUM_FN     = 4,
    parameter int                REG_W      = 8,
    parameter int                ADDR_W     = 3,
    parameter logic [NUM_FN-1:0] FN_HAS_OUT = 4'b1011,
    parameter logic [NUM_FN-1:0] FN_HAS_IN  = 4'b1101
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic [NUM_FN-1:0]   fn_out_i,
    input  logic [NUM_FN-1:0]   fn_oe_i,
    output logic [NUM_FN-1:0]   fn_in_o,
    input  logic [NUM_PADS-1:0] pad_in_i,
    output logic [NUM_PADS-1:0] pad_out_o,
    output logic [NUM_PADS-1:0] pad_oe_o
);

    logic [NUM_PADS-1:0][SEL_W-1:0]  pad_sel;
    logic [NUM_PADS-1:0]             gpio_out;
    logic [NUM_PADS-1:0]             gpio_dir;
    logic [NUM_FN-1:0][NUM_PADS-1:0] hit;
    logic                            unused_hit;

    padmux_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .pad_in_i   (pad_in_i),
        .pad_sel_o  (pad_sel),
        .gpio_out_o (gpio_out),
        .gpio_dir_o (gpio_dir)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        padmux_pad_sel #(
            .PAD_IDX    (p),
            .NUM_FN     (NUM_FN),
            .FN_HAS_OUT (FN_HAS_OUT),
            .FN_HAS_IN  (FN_HAS_IN)
        ) sel_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sel_i      (pad_sel[p]),
            .gpio_out_i (gpio_out[p]),
            .gpio_dir_i (gpio_dir[p]),
            .fn_out_i   (fn_out_i),
            .fn_oe_i    (fn_oe_i),
            .pad_out_o  (pad_out_o[p]),
            .pad_oe_o   (pad_oe_o[p])
        );
    end

    always_comb begin
        for (int f = 0; f < NUM_FN; f++) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                hit[f][p] = (pad_sel[p] != '0) &&
                            (choice_fn(p, int'(pad_sel[p]), NUM_FN) == f);
            end
        end
    end

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
        if (FN_HAS_IN[f]) begin : g_listen
            padmux_in_prio #(
                .NUM_PADS (NUM_PADS)
            ) prio_i (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .hit_i    (hit[f]),
                .pad_in_i (pad_in_i),
                .fn_in_o  (fn_in_o[f])
            );
        end else begin : g_mute
            assign fn_in_o[f] = 1'b0;
        end
    end

    assign unused_hit = ^hit;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> pad_oe_o == '0 && pad_out_o == '0); // R1

endmodule

// File: tb/padmux_top_tb_top.sv
module padmux_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] fn_out = '0;
    logic [3:0] fn_oe = '0;
    logic [3:0] fn_in;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    padmux_top dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .fn_out_i  (fn_out),
        .fn_oe_i   (fn_oe),
        .fn_in_o   (fn_in),
        .pad_in_i  (pad_in),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    // {sel0, sel1, gpio_out, gpio_dir, fn_out, fn_oe, pad_in, exp_pad_out, exp_pad_oe, exp_fn_in}
    localparam logic [67:0] VEC [5] = '{
        {8'h00, 8'h00, 8'hA5, 8'h0F, 4'h0, 4'h0, 8'h3C, 8'hA5, 8'h0F, 4'h0},
        {8'h55, 8'h55, 8'h00, 8'h00, 4'h6, 4'h8, 8'hB4, 8'h22, 8'hAA, 4'h4},
        {8'h00, 8'h55, 8'h0F, 8'h03, 4'h9, 4'h1, 8'hF0, 8'h9F, 8'h33, 4'hD},
        {8'h7F, 8'h4E, 8'h40, 8'h40, 4'h8, 4'h8, 8'h05, 8'hEA, 8'hFA, 4'h5},
        {8'h7F, 8'h4E, 8'h00, 8'h40, 4'h9, 4'h1, 8'hA2, 8'hAE, 8'h54, 4'h8}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet while held in reset
        repeat (2) @(negedge clk);
        chk("R1 pad_oe in reset", 32'(pad_oe), 32'h0);
        chk("R1 pad_out in reset", 32'(pad_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd_chk("R1 register zero", 3'(a), 8'h00);
        chk("R9 fn_in with nothing routed", 32'(fn_in), 32'h0);

        // R11: write timing, pad0 to bidirectional function 0
        fn_out = 4'h1; fn_oe = 4'h1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
        #5;
        chk("R11 pad_oe before edge", 32'(pad_oe[0]), 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 pad_oe after edge", 32'(pad_oe[0]), 32'h1);
        chk("R11 pad_out after edge", 32'(pad_out[0]), 32'h1);
        rd_chk("R11 readback", 3'd0, 8'h01);

        // R12: read-only and unmapped writes
        wr(3'd4, 8'hFF);
        wr(3'd7, 8'hFF);
        rd_chk("R12 sel0 kept", 3'd0, 8'h01);
        for (int a = 1; a < 4; a++) rd_chk("R12 register kept", 3'(a), 8'h00);
        #1;
        chk("R12 pad_oe kept", 32'(pad_oe), 32'h01);

        // vector table: R2..R10
        for (int v = 0; v < 5; v++) begin
            wr(3'd0, VEC[v][67:60]);
            wr(3'd1, VEC[v][59:52]);
            wr(3'd2, VEC[v][51:44]);
            wr(3'd3, VEC[v][43:36]);
            fn_out = VEC[v][35:32];
            fn_oe  = VEC[v][31:28];
            pad_in = VEC[v][27:20];
            #2;
            chk("R2 R3 R4 R5 R6 R7 pad_out", 32'(pad_out), 32'(VEC[v][19:12]));
            chk("R2 R3 R4 R5 R6 R7 pad_oe", 32'(pad_oe), 32'(VEC[v][11:4]));
            chk("R8 R9 fn_in", 32'(fn_in), 32'(VEC[v][3:0]));
            rd_chk("R10 pad levels", 3'd4, VEC[v][27:20]);
            rd_chk("R11 sel1 readback", 3'd1, VEC[v][59:52]);
        end

        // R1: asynchronous reset clears a live configuration
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        chk("R9 fn_in after reset", 32'(fn_in), 32'h0);
        rd_chk("R1 sel0 after reset", 3'd0, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule